// File: doc/BRIEF.md
# Packed Audio Word Sample Unpacker

This block sits between an audio sample FIFO and a serial audio transmitter. It accepts 64-bit words, each holding several PCM samples packed side by side in equal lanes. It hands the samples out one at a time. A container-type code selects the lane layout: eight 8-bit lanes, four 16-bit lanes or two 32-bit lanes. Samples are right justified inside their lanes. A 5-bit field gives the index of the sample's most significant bit, which is the sample width minus one.

Each lane is realigned into a 28-bit output field. The sample MSB always lands on bit 27, and the vacated low bits are zero. Lane bits above the programmed MSB are discarded. Lanes leave in order from the least significant end of the word. Each sample carries a channel flag that alternates between the two stereo channels, or stays at zero in mono.

The type code and the MSB position are captured together with each word. A word is therefore always unpacked with the settings that were present when it was accepted. Input and output both use valid/ready handshakes. A new word is taken only after every lane of the current word has been handed out.

Top module: `pcm_word_unpacker`

## Requirements
- R1: While rst_ni is low and after it rises with no word offered, word_ready_o is 1, smp_valid_o is 0 and smp_chan_o is 0.
- R2: word_ready_o is 1 exactly when no lane of an accepted word remains to be handed out. A word accepted at a clock edge presents its first sample from that edge on.
- R3: Type code 0 unpacks eight 8-bit lanes, bits [7:0] first and bits [63:56] last.
- R4: Type code 2 unpacks four 16-bit lanes, bits [15:0] first.
- R5: Type code 4 unpacks two 32-bit lanes, bits [31:0] first.
- R6: Type codes 1, 3, 5, 6 and 7 behave as type code 4.
- R7: For an MSB position m of 27 or less, output bit 27 carries lane bit m, and output bit 27-k carries lane bit m-k for k up to m. Output bits below 27-m are zero, and lane bits above m do not affect the output.
- R8: While smp_valid_o is 1 and smp_ready_i is 0, smp_o and smp_chan_o hold their values and no lane is consumed.
- R9: With stereo_i at 1 during a sample handshake, smp_chan_o inverts for the next sample, continuing across word boundaries. With stereo_i at 0 during a handshake, the next sample's smp_chan_o is 0.
- R10: type_i and msb_pos_i are sampled only when a word is accepted. Changing them while a word is being unpacked does not alter that word's samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| type_i | input | 3 | Container type code (0: 8-bit, 2: 16-bit, 4 and others: 32-bit lanes) |
| msb_pos_i | input | 5 | Sample MSB index inside a lane (sample width minus one) |
| stereo_i | input | 1 | 1: channel flag alternates, 0: channel flag forced to 0 |
| word_valid_i | input | 1 | Packed word offered |
| word_i | input | 64 | Packed word |
| word_ready_o | output | 1 | Word may be accepted |
| smp_valid_o | output | 1 | Aligned sample present |
| smp_o | output | 28 | Aligned sample, MSB at bit 27 |
| smp_chan_o | output | 1 | Channel flag of the sample (0: first channel, 1: second) |
| smp_ready_i | input | 1 | Sample taken by the transmitter |

## Verification
The embedded properties guard the temporal rules on every cycle. These are: a sample appears right after a word is accepted, samples hold steady under backpressure, the configuration stays frozen during unpacking, the channel flag alternates or clears, and the padding bits below the aligned MSB are zero. The lane order, the lane decoding for every type code and the exact bit placement depend on the data. Only the bench's scenarios can show them. For those, a queue-based model predicts every sample and compares it on every clock. The scenarios include garbage above the MSB, mid-word configuration changes and irregular ready patterns.

// File: rtl/pcm_unpack_pkg.sv
package pcm_unpack_pkg;
  typedef enum logic [1:0] {
    CONT_8  = 2'd0,
    CONT_16 = 2'd1,
    CONT_32 = 2'd2
  } cont_e;

  // unlisted codes fall back to 32-bit lanes
  function automatic cont_e cont_of(input logic [2:0] code);
    case (code)
      3'd0:    return CONT_8;
      3'd2:    return CONT_16;
      default: return CONT_32;
    endcase
  endfunction
endpackage

// File: rtl/pcm_lane_pick.sv
module pcm_lane_pick
  import pcm_unpack_pkg::*;
#(
  parameter int WORD_W = 64,
  parameter int LANE_W = 32,
  parameter int IDX_W  = $clog2(WORD_W / 8)
) (
  input  logic [WORD_W-1:0] word_i,
  input  cont_e             cont_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [LANE_W-1:0] lane_o
);
  localparam int NCONT = 3;

  logic [LANE_W-1:0] pick [NCONT];

  for (genvar g = 0; g < NCONT; g++) begin : g_cont
    localparam int LW  = 8 << g;
    localparam int NL  = WORD_W / LW;
    localparam int SLW = (NL > 1) ? $clog2(NL) : 1;
    logic [LW-1:0] lanes [NL];
    for (genvar l = 0; l < NL; l++) begin : g_lane
      assign lanes[l] = word_i[l*LW +: LW];
    end
    assign pick[g] = LANE_W'(lanes[idx_i[SLW-1:0]]);
  end

  always_comb begin
    case (cont_i)
      CONT_8:  lane_o = pick[0];
      CONT_16: lane_o = pick[1];
      default: lane_o = pick[2];
    endcase
  end
endmodule

// File: rtl/pcm_msb_align.sv
module pcm_msb_align #(
  parameter int IN_W  = 32,
  parameter int OUT_W = 28,
  parameter int POS_W = 5
) (
  input  logic [IN_W-1:0]  lane_i,
  input  logic [POS_W-1:0] msb_i,
  output logic [OUT_W-1:0] smp_o
);
  localparam int TOP = OUT_W - 1;

  logic [IN_W:0]         mask_w;
  logic [IN_W-1:0]       keep;
  logic [IN_W+OUT_W-1:0] wide;

  always_comb begin
    mask_w = ((IN_W+1)'(1) << (int'(msb_i) + 1)) - (IN_W+1)'(1);
    keep   = lane_i & mask_w[IN_W-1:0];
    if (int'(msb_i) >= TOP)
      wide = (IN_W+OUT_W)'(keep) >> (int'(msb_i) - TOP);
    else
      wide = (IN_W+OUT_W)'(keep) << (TOP - int'(msb_i));
    smp_o = wide[OUT_W-1:0];
  end
endmodule

// File: rtl/pcm_unpack_ctrl.sv
module pcm_unpack_ctrl #(
  parameter int IDX_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             word_fire_i,
  input  logic             smp_fire_i,
  input  logic             last_lane_i,
  input  logic             stereo_i,
  output logic             busy_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             chan_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      idx_o  <= '0;
      chan_o <= 1'b0;
    end else begin
      if (word_fire_i) begin
        busy_o <= 1'b1;
        idx_o  <= '0;
      end else if (smp_fire_i) begin
        if (last_lane_i) begin
          busy_o <= 1'b0;
          idx_o  <= '0;
        end else begin
          idx_o <= idx_o + 1'b1;
        end
      end
      if (smp_fire_i) chan_o <= stereo_i ? ~chan_o : 1'b0;
    end
  end

  AST_IDX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !smp_fire_i |=> busy_o && $stable(idx_o)); // R8

  AST_MONO_CHAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_fire_i && !stereo_i |=> !chan_o); // R9
endmodule

// File: rtl/pcm_word_unpacker.sv
module pcm_word_unpacker
  import pcm_unpack_pkg::*;
#(
  parameter int WORD_W = 64,
  parameter int LANE_W = 32,
  parameter int OUT_W  = 28,
  parameter int POS_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        type_i,
  input  logic [POS_W-1:0]  msb_pos_i,
  input  logic              stereo_i,
  input  logic              word_valid_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              word_ready_o,
  output logic              smp_valid_o,
  output logic [OUT_W-1:0]  smp_o,
  output logic              smp_chan_o,
  input  logic              smp_ready_i
);
  localparam int IDX_W = $clog2(WORD_W / 8);
  localparam int TOP   = OUT_W - 1;

  logic [WORD_W-1:0] word_q;
  cont_e             cont_q;
  logic [POS_W-1:0]  msb_q;
  logic              busy;
  logic [IDX_W-1:0]  idx;
  logic [IDX_W-1:0]  last_idx;
  logic [LANE_W-1:0] lane;
  logic              word_fire;
  logic              smp_fire;

  assign word_ready_o = !busy;
  assign smp_valid_o  = busy;
  assign word_fire    = word_valid_i && word_ready_o;
  assign smp_fire     = smp_valid_o && smp_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      cont_q <= CONT_32;
      msb_q  <= '0;
    end else if (word_fire) begin
      word_q <= word_i;
      cont_q <= cont_of(type_i);
      msb_q  <= msb_pos_i;
    end
  end

  always_comb begin
    case (cont_q)
      CONT_8:  last_idx = IDX_W'(WORD_W / 8 - 1);
      CONT_16: last_idx = IDX_W'(WORD_W / 16 - 1);
      default: last_idx = IDX_W'(WORD_W / 32 - 1);
    endcase
  end

  pcm_unpack_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .word_fire_i (word_fire),
    .smp_fire_i  (smp_fire),
    .last_lane_i (idx == last_idx),
    .stereo_i    (stereo_i),
    .busy_o      (busy),
    .idx_o       (idx),
    .chan_o      (smp_chan_o)
  );

  pcm_lane_pick #(.WORD_W(WORD_W), .LANE_W(LANE_W), .IDX_W(IDX_W)) u_pick (
    .word_i (word_q),
    .cont_i (cont_q),
    .idx_i  (idx),
    .lane_o (lane)
  );

  pcm_msb_align #(.IN_W(LANE_W), .OUT_W(OUT_W), .POS_W(POS_W)) u_align (
    .lane_i (lane),
    .msb_i  (msb_q),
    .smp_o  (smp_o)
  );

  logic [OUT_W-1:0] pad_mask;
  always_comb begin
    if (int'(msb_q) < TOP) pad_mask = (OUT_W'(1) << (TOP - int'(msb_q))) - OUT_W'(1);
    else                   pad_mask = '0;
  end

  AST_ACCEPT_SHOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_fire |=> smp_valid_o && !word_ready_o); // R2

  AST_LANE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_valid_o |-> idx <= last_idx); // R3

  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_valid_o && !smp_ready_i |=> smp_valid_o && $stable(smp_o) && $stable(smp_chan_o)); // R8

  AST_CHAN_ALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_fire && stereo_i |=> smp_chan_o != $past(smp_chan_o)); // R9

  AST_PAD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_valid_o |-> (smp_o & pad_mask) == '0); // R7

  AST_CFG_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_valid_o |=> $stable(cont_q) && $stable(msb_q)); // R10
endmodule

// File: tb/pcm_word_unpacker_tb.sv
module pcm_word_unpacker_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  type_i = '0;
  logic [4:0]  msb_pos_i = '0;
  logic        stereo_i = 1'b0;
  logic        word_valid_i = 1'b0;
  logic [63:0] word_i = '0;
  logic        word_ready_o;
  logic        smp_valid_o;
  logic [27:0] smp_o;
  logic        smp_chan_o;
  logic        smp_ready_i = 1'b0;

  always #4 clk_i = ~clk_i;

  pcm_word_unpacker dut_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .type_i       (type_i),
    .msb_pos_i    (msb_pos_i),
    .stereo_i     (stereo_i),
    .word_valid_i (word_valid_i),
    .word_i       (word_i),
    .word_ready_o (word_ready_o),
    .smp_valid_o  (smp_valid_o),
    .smp_o        (smp_o),
    .smp_chan_o   (smp_chan_o),
    .smp_ready_i  (smp_ready_i)
  );

  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;
  logic [27:0] exp_q[$];
  logic        chan_m = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%h exp=%h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic [27:0] ref_smp(input logic [63:0] w, input logic [2:0] t,
                                          input logic [4:0] m, input int k);
    int lw;
    longint unsigned lane, keep, o;
    lw   = (t == 3'd0) ? 8 : (t == 3'd2) ? 16 : 32;
    lane = (w >> (k * lw)) & ((64'd1 << lw) - 64'd1);
    keep = lane & ((64'd1 << (int'(m) + 1)) - 64'd1);
    o    = (m <= 5'd27) ? (keep << (27 - int'(m))) : (keep >> (int'(m) - 27));
    return o[27:0];
  endfunction

  task automatic step(input logic wv, input logic [63:0] w, input logic [2:0] t,
                      input logic [4:0] m, input logic st, input logic rdy, input string tag);
    int n;
    @(negedge clk_i);
    chk(word_ready_o === (exp_q.size() == 0), tag, "word_ready_o", 64'(word_ready_o), 64'(exp_q.size() == 0));
    chk(smp_valid_o === (exp_q.size() != 0), tag, "smp_valid_o", 64'(smp_valid_o), 64'(exp_q.size() != 0));
    if (exp_q.size() != 0) begin
      chk(smp_o === exp_q[0], tag, "smp_o", 64'(smp_o), 64'(exp_q[0]));
      chk(smp_chan_o === chan_m, tag, "smp_chan_o", 64'(smp_chan_o), 64'(chan_m));
    end
    word_valid_i = wv; word_i = w; type_i = t; msb_pos_i = m;
    stereo_i = st; smp_ready_i = rdy;
    if (exp_q.size() != 0) begin
      if (rdy) begin
        void'(exp_q.pop_front());
        chan_m = st ? ~chan_m : 1'b0;
      end
    end else if (wv) begin
      n = (t == 3'd0) ? 8 : (t == 3'd2) ? 4 : 2;
      for (int k = 0; k < n; k++) exp_q.push_back(ref_smp(w, t, m, k));
    end
  endtask

  task automatic run(input int n, input logic wv, input logic [63:0] w, input logic [2:0] t,
                     input logic [4:0] m, input logic st, input bit gappy, input string tag);
    for (int i = 0; i < n; i++) step(wv, w, t, m, st, gappy ? (i % 3 != 2) : 1'b1, tag);
  endtask

  task automatic drain(input string tag);
    run(12, 1'b0, 64'd0, 3'd4, 5'd23, 1'b1, 1'b0, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk(word_ready_o === 1'b1, "R1", "reset word_ready_o", 64'(word_ready_o), 64'd1);
    chk(smp_valid_o === 1'b0, "R1", "reset smp_valid_o", 64'(smp_valid_o), 64'd0);
    chk(smp_chan_o === 1'b0, "R1", "reset smp_chan_o", 64'(smp_chan_o), 64'd0);
    rst_ni = 1'b1;
    run(3, 1'b0, 64'd0, 3'd0, 5'd7, 1'b1, 1'b0, "R1");

    run(10, 1'b1, 64'h8877_6655_4433_2211, 3'd0, 5'd7, 1'b1, 1'b0, "R3");
    drain("R3");
    run(6, 1'b1, 64'h1234_ABCD_8001_7FFF, 3'd2, 5'd15, 1'b1, 1'b0, "R4");
    drain("R4");
    run(3, 1'b1, 64'h00AB_CDEF_0012_3456, 3'd4, 5'd23, 1'b1, 1'b0, "R5");
    drain("R5");
    for (int c = 1; c < 8; c += 2) begin
      run(3, 1'b1, 64'h0F0E_0D0C_0B0A_0908 ^ 64'(c), 3'(c), 5'd23, 1'b1, 1'b0, "R6");
      drain("R6");
    end
    run(1, 1'b1, 64'h0000_0000_0000_0000, 3'd6, 5'd23, 1'b1, 1'b0, "R6");
    drain("R6");
    run(3, 1'b1, 64'hFFF1_2345_ABC6_789A, 3'd4, 5'd19, 1'b1, 1'b0, "R7");
    drain("R7");
    run(5, 1'b1, 64'hFF80_1234_ABCD_0081, 3'd2, 5'd7, 1'b1, 1'b0, "R7");
    drain("R7");
    run(3, 1'b1, 64'hFFFF_8001_1234_FFFF, 3'd4, 5'd15, 1'b1, 1'b0, "R7");
    drain("R7");
    run(30, 1'b1, 64'hA5A5_5A5A_C3C3_3C3C, 3'd0, 5'd7, 1'b1, 1'b1, "R8");
    drain("R8");
    run(30, 1'b1, 64'h0102_0304_0506_0708, 3'd2, 5'd15, 1'b1, 1'b0, "R2");
    drain("R2");
    run(1, 1'b1, 64'h7777_0000_1111_2222, 3'd0, 5'd7, 1'b0, 1'b0, "R9");
    run(12, 1'b1, 64'h3333_4444_5555_6666, 3'd2, 5'd15, 1'b0, 1'b1, "R9");
    run(9, 1'b1, 64'h1357_9BDF_2468_ACE0, 3'd4, 5'd23, 1'b1, 1'b1, "R9");
    drain("R9");
    run(1, 1'b1, 64'hF0E1_D2C3_B4A5_9687, 3'd0, 5'd7, 1'b1, 1'b0, "R10");
    run(12, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 3'd4, 5'd23, 1'b1, 1'b1, "R10");
    drain("R10");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog R2 act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule